// File: doc/BRIEF.md
# Byte/Word ALU with Status Word

This unit performs one arithmetic, logical or single-bit shift/rotate operation per cycle on either 8-bit or 16-bit operands. It also holds the 16-bit processor status word that the operation reads (for carry-in) and updates. The result is produced combinationally from the current inputs. The status word changes on the next rising clock edge when flag writing is enabled.

The status word also carries control bits: trap, interrupt enable, direction and a storable mode bit. A surrounding sequencer writes these through a separate whole-word load port. Some bit positions are hard-wired, whatever value is loaded. Instruction decode, register storage, memory traffic and interrupt entry belong to the surrounding core.

Top module: `alu_psw`

## Requirements
- R1: After reset (`rst_n` low) the status word reads 16'h7002.
- R2: Bits 14, 13, 12 and 1 of the status word always read 1. Bits 5 and 3 always read 0, whatever is loaded or computed.
- R3: `op` codes are: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 shift left, 8 logical shift right, 9 arithmetic shift right, 10 rotate left, 11 rotate right. `wide`=1 selects 16 bits and `wide`=0 selects 8 bits. In 8-bit mode the upper result byte is 0. Codes 12 to 15 give result 0 and leave every flag unchanged.
- R4: On codes 0 to 3, carry (bit 0) receives the carry/borrow out of the selected size. Auxiliary carry (bit 4) receives the carry or borrow between bit 3 and bit 4. Codes 1 and 3 consume the current carry flag.
- R5: Overflow (bit 11) is set for add when both operands share a sign and the result sign differs. It is set for subtract when the operand signs differ and the result sign differs from the first operand.
- R6: On arithmetic, logical and shift codes, sign (bit 7) copies the result MSB at the selected size. Zero (bit 6) is set when the sized result is 0. Parity (bit 2) is set when the low 8 result bits hold an even count of ones.
- R7: Logical codes 4 to 6 clear carry and overflow and keep auxiliary carry.
- R8: For shifts and rotates, carry receives the bit shifted out. Overflow is set as follows:
  - shift left and rotate left: result MSB XOR new carry;
  - logical shift right: original MSB;
  - arithmetic shift right: 0;
  - rotate right: XOR of the two top result bits.
  Shifts and rotates keep auxiliary carry. Rotates also keep sign, zero and parity.
- R9: With `psw_ld` high, the status word takes `psw_din` (fixed bits forced) at the next edge, ahead of any flag update in that cycle. The mode bit (bit 15) is stored.
- R10: With `flag_we` and `psw_ld` both low the status word holds. An ALU flag update never changes bits 15, 10, 9 and 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 4 | Operation code |
| wide | input | 1 | 1 = 16-bit operands, 0 = 8-bit |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| flag_we | input | 1 | Commit computed flags at the next edge |
| psw_ld | input | 1 | Load the whole status word |
| psw_din | input | 16 | Status word load value |
| result | output | 16 | Operation result |
| psw | output | 16 | Registered status word |

## Verification
A direct status-word load and an ALU flag commit can be requested in the same cycle. The bench provokes this both by raising `psw_ld` and `flag_we` together in random traffic and in directed cases. It judges the outcome by comparing the next status word with the masked load value, never the computed flags. Loads whose data violates the hard-wired bits are mixed in, and the carry-consuming operations that follow them confirm which value actually won.

// File: rtl/alu_psw.sv
module alu_psw (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  op,
  input  logic        wide,
  input  logic [15:0] a,
  input  logic [15:0] b,
  input  logic        flag_we,
  input  logic        psw_ld,
  input  logic [15:0] psw_din,
  output logic [15:0] result,
  output logic [15:0] psw
);
  localparam logic [15:0] ONES  = 16'h7002;
  localparam logic [15:0] ZEROS = 16'h0028;

  logic [15:0] am, bm, r, topbit, nf;
  logic [16:0] sum;
  logic        cin, as, bs, rs, cout, ovf, valid, upd_c, upd_o, upd_szp, upd_af;

  assign am     = wide ? a : {8'h00, a[7:0]};
  assign bm     = wide ? b : {8'h00, b[7:0]};
  assign topbit = wide ? 16'h8000 : 16'h0080;
  assign cin    = psw[0] & op[0];
  assign as     = wide ? a[15] : a[7];
  assign bs     = wide ? b[15] : b[7];

  always_comb begin
    sum = {1'b0, am} + {1'b0, bm} + {16'd0, cin};
    if (op == 4'd2 || op == 4'd3)
      sum = {1'b0, am} - {1'b0, bm} - {16'd0, cin};
  end

  always_comb begin
    r = 16'h0000; cout = 1'b0; valid = 1'b1;
    upd_c = 1'b1; upd_o = 1'b1; upd_szp = 1'b1; upd_af = 1'b0;
    case (op)
      4'd0, 4'd1, 4'd2, 4'd3: begin
        r = sum[15:0]; cout = wide ? sum[16] : sum[8]; upd_af = 1'b1;
      end
      4'd4: r = am & bm;
      4'd5: r = am | bm;
      4'd6: r = am ^ bm;
      4'd7: begin r = am << 1; cout = as; end
      4'd8: begin r = am >> 1; cout = am[0]; end
      4'd9: begin r = (am >> 1) | (as ? topbit : 16'h0000); cout = am[0]; end
      4'd10: begin r = (am << 1) | {15'd0, as}; cout = as; upd_szp = 1'b0; end
      4'd11: begin r = (am >> 1) | (am[0] ? topbit : 16'h0000); cout = am[0]; upd_szp = 1'b0; end
      default: begin valid = 1'b0; upd_c = 1'b0; upd_o = 1'b0; upd_szp = 1'b0; end
    endcase
    if (!wide) r[15:8] = 8'h00;
  end

  assign result = r;
  assign rs     = wide ? r[15] : r[7];

  always_comb begin
    case (op)
      4'd0, 4'd1:  ovf = (as == bs) && (rs != as);
      4'd2, 4'd3:  ovf = (as != bs) && (rs != as);
      4'd7, 4'd10: ovf = rs ^ cout;
      4'd8:        ovf = as;
      4'd11:       ovf = rs ^ (wide ? r[14] : r[6]);
      default:     ovf = 1'b0;
    endcase
  end

  always_comb begin
    nf = psw;
    if (valid) begin
      if (upd_c) nf[0] = cout;
      if (upd_o) nf[11] = ovf;
      if (upd_af) nf[4] = am[4] ^ bm[4] ^ r[4];
      if (upd_szp) begin
        nf[2] = ~^r[7:0];
        nf[6] = (r == 16'h0000);
        nf[7] = rs;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       psw <= ONES;
    else if (psw_ld)  psw <= (psw_din | ONES) & ~ZEROS;
    else if (flag_we) psw <= (nf | ONES) & ~ZEROS;
  end

  // R2
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psw[14:12] == 3'b111) && psw[1] && !psw[3] && !psw[5]);

  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psw_ld |=> psw == (($past(psw_din) | ONES) & ~ZEROS));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!psw_ld && !flag_we) |=> $stable(psw));

  // R10
  ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!psw_ld && flag_we) |=> (psw[15] == $past(psw[15])) && (psw[10:8] == $past(psw[10:8])));

  // R7
  logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!psw_ld && flag_we && op >= 4'd4 && op <= 4'd6) |=>
      !psw[0] && !psw[11] && (psw[4] == $past(psw[4])));

  // R3
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> result[15:8] == 8'h00);
endmodule

// File: tb/sim_alu_psw.sv
`timescale 1ns/1ps
module sim_alu_psw;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] op = 4'd0;
  logic wide = 1'b0, flag_we = 1'b0, psw_ld = 1'b0;
  logic [15:0] a = 16'h0, b = 16'h0, psw_din = 16'h0;
  logic [15:0] result, psw;
  int tests = 0, fails = 0;
  logic [15:0] ref_psw;

  always #2.5 clk = ~clk;

  alu_psw u0 (.clk(clk), .rst_n(rst_n), .op(op), .wide(wide), .a(a), .b(b),
              .flag_we(flag_we), .psw_ld(psw_ld), .psw_din(psw_din),
              .result(result), .psw(psw));

  function automatic logic [15:0] fixw(input logic [15:0] v);
    return (v | 16'h7002) & 16'hffd7;
  endfunction

  function automatic logic [31:0] model(input int o, input bit w, input int av,
                                        input int bv, input logic [15:0] f);
    int n, mask, sb, ua, ub, c, t, r, cf, of, af;
    logic [15:0] nf;
    bit szp, as, bs, rsn;
    nf = f; n = w ? 16 : 8; mask = (1 << n) - 1; sb = 1 << (n - 1);
    ua = av & mask; ub = bv & mask; c = (o == 1 || o == 3) ? int'(f[0]) : 0;
    as = (ua & sb) != 0; bs = (ub & sb) != 0;
    r = 0; cf = 0; of = 0; af = int'(f[4]); szp = 1;
    if (o > 11) return {16'h0000, f};
    case (o)
      0, 1: begin t = ua + ub + c; r = t & mask; cf = int'(t > mask);
        af = int'(((ua & 15) + (ub & 15) + c) > 15);
        rsn = (r & sb) != 0; of = int'(as == bs && rsn != as); end
      2, 3: begin t = ua - ub - c; r = t & mask; cf = int'(t < 0);
        af = int'(((ua & 15) - (ub & 15) - c) < 0);
        rsn = (r & sb) != 0; of = int'(as != bs && rsn != as); end
      4: r = ua & ub;
      5: r = ua | ub;
      6: r = ua ^ ub;
      7: begin r = (ua * 2) & mask; cf = int'(as); of = int'(((r & sb) != 0) != as); end
      8: begin r = ua / 2; cf = ua % 2; of = int'(as); end
      9: begin r = ua / 2 + (as ? sb : 0); cf = ua % 2; of = 0; end
      10: begin r = ((ua * 2) & mask) + int'(as); cf = int'(as);
        of = int'(((r & sb) != 0) != as); szp = 0; end
      default: begin r = ua / 2 + ((ua % 2) ? sb : 0); cf = ua % 2;
        of = int'(((r & sb) != 0) != ((r & (sb / 2)) != 0)); szp = 0; end
    endcase
    nf[0] = cf[0]; nf[11] = of[0]; nf[4] = af[0];
    if (szp) begin
      nf[7] = (r & sb) != 0; nf[6] = (r == 0);
      nf[2] = ($countones(r & 255) % 2) == 0;
    end
    return {r[15:0], fixw(nf)};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int o, input bit we, input bit ld);
    if (ld) return "R9";
    if (!we) return "R10";
    if (o < 2) return "R4";
    if (o < 4) return "R5";
    if (o < 7) return "R7";
    if (o < 12) return "R8";
    return "R3";
  endfunction

  task automatic apply(input int o, input bit w, input logic [15:0] av, input logic [15:0] bv,
                       input bit we, input bit ld, input logic [15:0] din);
    logic [31:0] m;
    @(negedge clk);
    op = o[3:0]; wide = w; a = av; b = bv; flag_we = we; psw_ld = ld; psw_din = din;
    #1;
    m = model(o, w, av, bv, ref_psw);
    check("R3 result", result, m[31:16]);
    if (ld) ref_psw = fixw(din);
    else if (we) ref_psw = m[15:0];
    @(posedge clk); #1;
    check({tag_of(o, we, ld), " R6 psw"}, psw, ref_psw);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", psw, 16'h7002);
    @(negedge clk); rst_n = 1'b1;
    ref_psw = 16'h7002;
    check("R2 fixed", psw & 16'h702a, 16'h7002);
    apply(0, 0, 16'h007f, 16'h0001, 1, 0, 0);
    apply(0, 0, 16'h00ff, 16'h0001, 1, 0, 0);
    apply(1, 0, 16'h0010, 16'h0020, 1, 0, 0);
    apply(2, 1, 16'h8000, 16'h0001, 1, 0, 0);
    apply(3, 1, 16'h0000, 16'h0000, 1, 0, 0);
    apply(3, 1, 16'h1234, 16'h1234, 1, 0, 0);
    apply(6, 1, 16'hffff, 16'h00ff, 1, 0, 0);
    apply(7, 0, 16'h0040, 16'h0000, 1, 0, 0);
    apply(9, 1, 16'h8001, 16'h0000, 1, 0, 0);
    apply(11, 0, 16'h0001, 16'h0000, 1, 0, 0);
    apply(10, 1, 16'h8000, 16'h0000, 1, 0, 0);
    apply(13, 1, 16'hffff, 16'h0001, 1, 0, 0);
    apply(0, 1, 16'hffff, 16'h0001, 0, 0, 0);
    apply(0, 1, 16'hffff, 16'h0001, 1, 1, 16'h0028);
    apply(0, 0, 16'h0000, 16'h0000, 0, 1, 16'h8f01);
    apply(1, 0, 16'h0000, 16'h0000, 1, 0, 0);
    apply(8, 1, 16'h8003, 16'h0000, 1, 0, 0);
    for (int i = 0; i < 600; i++) begin
      int o;
      o = $urandom_range(0, 12);
      apply(o, $urandom_range(0, 1), 16'($urandom), 16'($urandom),
            $urandom_range(0, 7) != 0, $urandom_range(0, 9) == 0, 16'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule